// File: doc/BRIEF.md
# Two-Memory March Self-Test Engine

This block is an at-speed self-test engine for two identical single-port SRAMs of the same size. After a start pulse it runs a six-element March sequence over memory 0 and then over memory 1. It drives a shared address and write-data bus, and a write strobe and read strobe for each memory. Every read is compared one cycle later against the value the sequence expects. There are no wait states, so every cycle of the run is a memory access.

When both memories are done, the engine raises `done` and holds it, together with a sticky `fail` flag, until the next start. Only one failure record is kept: the memory index, address, data read back and data expected for the most recent miscompare. Each new miscompare replaces the previous record, so after the run the record describes the last failing access in test order.

Top module: `march_bist`

## Requirements
- R1: While reset is held and after it is released, `done` and `fail` are 0 and no write or read strobe is asserted.
- R2: `start` is sampled when `done` is high or before the first test. The test then runs to completion. `done` first reads 1 in the cycle that follows clock edge number 20*DEPTH+2, counting the edge that sampled `start` as edge 1. `done` stays high until the next start. A `start` pulse during a run changes nothing.
- R3: At most one strobe of `mem_we`/`mem_re` is high in any cycle. Bit 0 of each strobe vector belongs to memory 0 and bit 1 to memory 1. All accesses to memory 0 come before any access to memory 1.
- R4: A run makes exactly 20*DEPTH accesses in 20*DEPTH consecutive cycles, with no idle cycle between them. No strobe is asserted while `done` is high.
- R5: `fail` is 1 after a run if and only if at least one read in either memory returned data different from the expected word.
- R6: The failure record (`fail_addr`, `fail_rdata`) holds the address and read data of the last miscompare in test order. The sequence is: up w0; up r0,w1; up r1,w0; down r0,w1; down r1,w0; up r0. Memory 0 is tested first, then memory 1.
- R7: The failure record also holds the index of the failing memory (`fail_mem`) and the expected word (`fail_expect`).
- R8: A new start clears `fail` in the cycle after the edge that samples it.
- R9: The value "0" of the sequence is the parameter BACKGROUND, and "1" is its bitwise inverse. With no faults, every word of both memories holds BACKGROUND at the end of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a test |
| mem_addr | output | ADDR_W | Shared SRAM address |
| mem_wdata | output | DATA_W | Shared SRAM write data |
| mem_we | output | MEM_CNT | Write strobe per memory |
| mem_re | output | MEM_CNT | Read strobe per memory |
| mem_rdata | input | MEM_CNT*DATA_W | Read data, memory g in slice g; valid one cycle after the read strobe |
| done | output | 1 | Test complete, held until next start |
| fail | output | 1 | Sticky miscompare flag |
| fail_mem | output | MEM_W | Memory index of last miscompare |
| fail_addr | output | ADDR_W | Address of last miscompare |
| fail_rdata | output | DATA_W | Data read at last miscompare |
| fail_expect | output | DATA_W | Expected data at last miscompare |

## Verification
The bench targets the following cases, each of which an incorrect engine would get wrong:
- Two stuck cells in one memory. An engine that kept the first failure would report the lower address from an early element instead of the higher address from the final ascending read.
- A fault in memory 0 together with a fault in memory 1. The record must end up naming memory 1; an engine that mixed up the memory order or the read-data slice would name memory 0.
- A write-triggered coupling fault whose victim sits above its aggressor. The victim fails again in the final element with a known value; comparing against a stale expected word would give a different record.
- A start pulse during a run, which must not move the finish cycle.
- A fault-free run after a failing one, which must clear `fail`.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

   // One March element: direction, optional read and its polarity,
   // optional write and its polarity.
   typedef struct packed {
      logic down;
      logic rd;
      logic rd_one;
      logic wr;
      logic wr_one;
   } march_elem_t;

   localparam int ELEM_CNT = 6;
   localparam int ELEM_W   = 3;
   localparam logic [ELEM_W-1:0] ELEM_LAST = ELEM_W'(ELEM_CNT - 1);

   function automatic march_elem_t elem_info(input logic [ELEM_W-1:0] idx);
      march_elem_t e;
      case (idx)
         3'd0:    e = '{down:1'b0, rd:1'b0, rd_one:1'b0, wr:1'b1, wr_one:1'b0};
         3'd1:    e = '{down:1'b0, rd:1'b1, rd_one:1'b0, wr:1'b1, wr_one:1'b1};
         3'd2:    e = '{down:1'b0, rd:1'b1, rd_one:1'b1, wr:1'b1, wr_one:1'b0};
         3'd3:    e = '{down:1'b1, rd:1'b1, rd_one:1'b0, wr:1'b1, wr_one:1'b1};
         3'd4:    e = '{down:1'b1, rd:1'b1, rd_one:1'b1, wr:1'b1, wr_one:1'b0};
         default: e = '{down:1'b0, rd:1'b1, rd_one:1'b0, wr:1'b0, wr_one:1'b0};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/march_bist_seq.sv
module march_bist_seq
   import march_bist_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int MEM_CNT = 2,
   parameter int MEM_W = 1,
   parameter logic [DATA_W-1:0] BACKGROUND = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              clr,
   output logic              rd_issue,
   output logic              wr_issue,
   output logic [MEM_W-1:0]  acc_mem,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_expect,
   output logic              done
);

   localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
   localparam logic [MEM_W-1:0]  MEM_LAST = MEM_W'(MEM_CNT - 1);

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH, S_DONE} seq_state_t;

   seq_state_t        st_q;
   logic [MEM_W-1:0]  mem_q;
   logic [ELEM_W-1:0] elem_q;
   logic [ADDR_W-1:0] addr_q;
   logic              phase_q;

   march_elem_t e, e_next;
   logic at_end, step_last, accept;

   always_comb begin
      e         = elem_info(elem_q);
      e_next    = elem_info(elem_q + 1'b1);
      at_end    = e.down ? (addr_q == '0) : (addr_q == ADDR_MAX);
      step_last = !(e.rd && e.wr) || phase_q;
      accept    = start && (st_q == S_IDLE || st_q == S_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         mem_q   <= '0;
         elem_q  <= '0;
         addr_q  <= '0;
         phase_q <= 1'b0;
      end else if (accept) begin
         st_q    <= S_RUN;
         mem_q   <= '0;
         elem_q  <= '0;
         addr_q  <= '0;
         phase_q <= 1'b0;
      end else begin
         case (st_q)
            S_RUN: begin
               if (!step_last) begin
                  phase_q <= 1'b1;
               end else begin
                  phase_q <= 1'b0;
                  if (!at_end) begin
                     addr_q <= e.down ? addr_q - 1'b1 : addr_q + 1'b1;
                  end else if (elem_q != ELEM_LAST) begin
                     elem_q <= elem_q + 1'b1;
                     addr_q <= e_next.down ? ADDR_MAX : '0;
                  end else if (mem_q != MEM_LAST) begin
                     mem_q  <= mem_q + 1'b1;
                     elem_q <= '0;
                     addr_q <= '0;
                  end else begin
                     st_q <= S_FLUSH;
                  end
               end
            end
            S_FLUSH: st_q <= S_DONE;
            default: st_q <= st_q;
         endcase
      end
   end

   always_comb begin
      clr        = accept;
      rd_issue   = (st_q == S_RUN) && e.rd && !phase_q;
      wr_issue   = (st_q == S_RUN) && e.wr && (phase_q || !e.rd);
      acc_mem    = mem_q;
      acc_addr   = addr_q;
      acc_wdata  = e.wr_one ? ~BACKGROUND : BACKGROUND;
      acc_expect = e.rd_one ? ~BACKGROUND : BACKGROUND;
      done       = (st_q == S_DONE);
   end

   // A start pulse in mid-run must not disturb the sequence.
   assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RUN && start) |=> (st_q == S_RUN || st_q == S_FLUSH));

   // While running, exactly one access is issued each cycle.
   assert_at_speed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RUN) |-> (rd_issue ^ wr_issue));

endmodule

// File: rtl/march_bist_cmp.sv
module march_bist_cmp #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int MEM_CNT = 2,
   parameter int MEM_W = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      rd_issue,
   input  logic [MEM_W-1:0]          acc_mem,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [DATA_W-1:0]         acc_expect,
   input  logic [MEM_CNT*DATA_W-1:0] rdata_bus,
   output logic                      fail,
   output logic [MEM_W-1:0]          fail_mem,
   output logic [ADDR_W-1:0]         fail_addr,
   output logic [DATA_W-1:0]         fail_rdata,
   output logic [DATA_W-1:0]         fail_expect
);

   // Read issued last cycle: its context waits for the data.
   logic              pv_q;
   logic [MEM_W-1:0]  pmem_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [DATA_W-1:0] pexp_q;

   logic [DATA_W-1:0] rd_sel;
   logic              miscmp;

   always_comb begin
      rd_sel = '0;
      for (int g = 0; g < MEM_CNT; g++) begin
         if (pmem_q == MEM_W'(g)) rd_sel = rdata_bus[g*DATA_W +: DATA_W];
      end
      miscmp = pv_q && (rd_sel != pexp_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q    <= 1'b0;
         pmem_q  <= '0;
         paddr_q <= '0;
         pexp_q  <= '0;
      end else begin
         pv_q    <= rd_issue && !clr;
         pmem_q  <= acc_mem;
         paddr_q <= acc_addr;
         pexp_q  <= acc_expect;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail        <= 1'b0;
         fail_mem    <= '0;
         fail_addr   <= '0;
         fail_rdata  <= '0;
         fail_expect <= '0;
      end else if (clr) begin
         fail        <= 1'b0;
         fail_mem    <= '0;
         fail_addr   <= '0;
         fail_rdata  <= '0;
         fail_expect <= '0;
      end else if (miscmp) begin
         fail        <= 1'b1;
         fail_mem    <= pmem_q;
         fail_addr   <= paddr_q;
         fail_rdata  <= rd_sel;
         fail_expect <= pexp_q;
      end
   end

   assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> fail);

   assert_last_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (miscmp && !clr) |=> (fail_addr == $past(paddr_q) && fail_mem == $past(pmem_q)));

   assert_fail_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !fail);

endmodule

// File: rtl/march_bist.sv
module march_bist #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int MEM_CNT = 2,
   parameter logic [DATA_W-1:0] BACKGROUND = '0,
   parameter int MEM_W = (MEM_CNT > 1) ? $clog2(MEM_CNT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   output logic [MEM_CNT-1:0]        mem_we,
   output logic [MEM_CNT-1:0]        mem_re,
   input  logic [MEM_CNT*DATA_W-1:0] mem_rdata,
   output logic                      done,
   output logic                      fail,
   output logic [MEM_W-1:0]          fail_mem,
   output logic [ADDR_W-1:0]         fail_addr,
   output logic [DATA_W-1:0]         fail_rdata,
   output logic [DATA_W-1:0]         fail_expect
);

   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
      $error("march_bist: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("march_bist: DATA_W must be positive");
   end
   if (MEM_CNT < 1 || MEM_W < 1 || (1 << MEM_W) < MEM_CNT) begin : g_bad_mem
      $error("march_bist: MEM_CNT/MEM_W inconsistent");
   end

   logic              clr, rd_issue, wr_issue;
   logic [MEM_W-1:0]  acc_mem;
   logic [DATA_W-1:0] acc_expect;

   march_bist_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_CNT(MEM_CNT),
      .MEM_W(MEM_W), .BACKGROUND(BACKGROUND)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .clr(clr),
      .rd_issue(rd_issue), .wr_issue(wr_issue), .acc_mem(acc_mem),
      .acc_addr(mem_addr), .acc_wdata(mem_wdata), .acc_expect(acc_expect),
      .done(done)
   );

   // Per-memory strobe decode.
   for (genvar g = 0; g < MEM_CNT; g++) begin : g_strobe
      assign mem_we[g] = wr_issue && (acc_mem == MEM_W'(g));
      assign mem_re[g] = rd_issue && (acc_mem == MEM_W'(g));
   end

   march_bist_cmp #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_CNT(MEM_CNT), .MEM_W(MEM_W)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rd_issue(rd_issue),
      .acc_mem(acc_mem), .acc_addr(mem_addr), .acc_expect(acc_expect),
      .rdata_bus(mem_rdata), .fail(fail), .fail_mem(fail_mem),
      .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_expect(fail_expect)
   );

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re}));

   assert_quiet_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mem_we == '0 && mem_re == '0));

   assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

// File: tb/sim_march_bist.sv
module sim_march_bist;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;
   localparam logic [DW-1:0] BG = 8'h55;
   localparam int RUN_CYC = 20 * DEPTH;

   // {mode[24:22], fail[21], mem[20], addr[19:16], rdata[15:8], expect[7:0]}
   // mode 0 none, 1 mem1 a5 b2 stuck-1, 2 mem0 a2,a9 b0 stuck-0,
   // 3 mem0 write a3 flips a10 b4, 4 = modes 1 and 2.
   localparam logic [24:0] VEC [6] = '{
      {3'd1, 1'b1, 1'b1, 4'd5,  8'hAE, 8'hAA},
      {3'd2, 1'b1, 1'b0, 4'd9,  8'h54, 8'h55},
      {3'd3, 1'b1, 1'b0, 4'd10, 8'h45, 8'h55},
      {3'd4, 1'b1, 1'b1, 4'd5,  8'hAE, 8'hAA},
      {3'd0, 1'b0, 1'b0, 4'd0,  8'h00, 8'h00},
      {3'd3, 1'b1, 1'b0, 4'd10, 8'h45, 8'h55}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, fail_rdata, fail_expect;
   logic [1:0] mem_we, mem_re;
   logic [2*DW-1:0] mem_rdata;
   logic done, fail;
   logic [0:0] fail_mem;
   logic [AW-1:0] fail_addr;

   int checks = 0, errors = 0;
   int fmode = 0;

   always #10 clk = ~clk;

   march_bist #(.ADDR_W(AW), .DATA_W(DW), .MEM_CNT(2), .BACKGROUND(BG)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .done(done), .fail(fail), .fail_mem(fail_mem),
      .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_expect(fail_expect)
   );

   // Behavioral SRAMs with injectable faults.
   logic [DW-1:0] m0 [DEPTH];
   logic [DW-1:0] m1 [DEPTH];
   logic [DW-1:0] rd0, rd1;
   assign mem_rdata = {rd1, rd0};

   function automatic logic [DW-1:0] fault0(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if ((fmode == 2 || fmode == 4) && (a == 4'd2 || a == 4'd9)) return d & 8'hFE;
      return d;
   endfunction

   function automatic logic [DW-1:0] fault1(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if ((fmode == 1 || fmode == 4) && a == 4'd5) return d | 8'h04;
      return d;
   endfunction

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m0[i] = '0;
         m1[i] = '0;
      end
   end

   always @(posedge clk) begin
      if (mem_we[0]) begin
         m0[mem_addr] <= mem_wdata;
         if (fmode == 3 && mem_addr == 4'd3) m0[10] <= m0[10] ^ 8'h10;
      end
      if (mem_we[1]) m1[mem_addr] <= mem_wdata;
      if (mem_re[0]) rd0 <= fault0(mem_addr, m0[mem_addr]);
      if (mem_re[1]) rd1 <= fault1(mem_addr, m1[mem_addr]);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Runs one test; returns cycle of first done and number of access cycles.
   task automatic run_test(input bit poke_mid, output int n_done, output int n_acc,
                           output int first1);
      int n;
      n_acc = 0;
      first1 = -1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 1;
      while (!done && n < 2 * RUN_CYC) begin
         if ((mem_we | mem_re) != 2'b00) n_acc++;
         if (first1 < 0 && (mem_we[1] || mem_re[1])) first1 = n;
         if (n == 1) chk("R3 first access memory 0", {30'd0, mem_we}, 32'd1);
         if (poke_mid && n == 100) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      n_done = n;
   endtask

   initial begin
      int nd, na, f1;
      logic [24:0] v;
      repeat (3) @(negedge clk);
      chk("R1 done in reset", {31'd0, done}, 0);
      chk("R1 strobes in reset", {28'd0, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", {31'd0, done}, 0);
      chk("R1 fail after reset", {31'd0, fail}, 0);

      // Fault-free run with a mid-run start pulse.
      fmode = 0;
      run_test(1'b1, nd, na, f1);
      chk("R2 done cycle", nd, RUN_CYC + 2);
      chk("R4 access cycles", na, RUN_CYC);
      chk("R3 memory 1 begins after memory 0", f1, RUN_CYC / 2 + 1);
      chk("R5 clean pass", {31'd0, fail}, 0);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R9 final contents mem0", {24'd0, m0[i]}, {24'd0, BG});
         chk("R9 final contents mem1", {24'd0, m1[i]}, {24'd0, BG});
      end
      repeat (5) @(negedge clk);
      chk("R2 done held", {31'd0, done}, 1);
      chk("R4 no strobe while done", {28'd0, mem_we, mem_re}, 0);

      // Vector table.
      for (int k = 0; k < 6; k++) begin
         v = VEC[k];
         fmode = int'(v[24:22]);
         run_test(1'b0, nd, na, f1);
         chk("R2 done cycle", nd, RUN_CYC + 2);
         chk("R5 pass/fail flag", {31'd0, fail}, {31'd0, v[21]});
         if (v[21]) begin
            chk("R7 failing memory", {31'd0, fail_mem}, {31'd0, v[20]});
            chk("R6 last failing address", {28'd0, fail_addr}, {28'd0, v[19:16]});
            chk("R6 last failing data", {24'd0, fail_rdata}, {24'd0, v[15:8]});
            chk("R7 expected word", {24'd0, fail_expect}, {24'd0, v[7:0]});
         end
      end

      // Start after a failing run clears the sticky flag.
      fmode = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R8 fail cleared on start", {31'd0, fail}, 0);
      chk("R2 done dropped on start", {31'd0, done}, 0);
      while (!done) @(negedge clk);
      chk("R5 clean pass after clear", {31'd0, fail}, 0);

      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
   end

endmodule